// File: doc/BRIEF.md
# Dusk-Dawn Lamp Controller with Remote Toggle

This synchronous block decides whether a lamp is lit. It takes a clean day/night level from a light-sensing front end and a noisy level from a remote-control receiver. When the day/night level turns to night, the lamp is switched on. When it turns to day, the lamp is switched off. Each of these transitions makes its own one-cycle pulse on its own line. Between those forced changes, every accepted press of the remote flips the lamp. A press can flip it any number of times within one day or one night.

Both inputs pass through two-flop synchronizers. The remote level then passes a counter-based debouncer. Only the rising edge of the debounced level counts as a press. The dusk pulse, the dawn pulse and the press pulse are brought out as one-cycle status outputs so that a test can observe them. Reset is synchronous and active low.

Top module: `dusk_dawn_lamp`

## Requirements
- R1: While `rst_n` is low, `lamp_on` is 0 at each clock edge. Reset takes in the present input levels, so if the inputs hold steady through the release, no dusk, dawn or press pulse follows and `lamp_on` stays 0.
- R2: `day_night` is 1 for night and 0 for day. A 0-to-1 change raises `dusk_pulse` for exactly one cycle, and `lamp_on` is 1 from the following cycle.
- R3: A 1-to-0 change of `day_night` raises `dawn_pulse`, a separate line from `dusk_pulse`, for exactly one cycle, and `lamp_on` is 0 from the following cycle.
- R4: A new `remote_raw` level is accepted only after its synchronized copy has differed from the accepted level on `DEBOUNCE_CYCLES` consecutive clock edges. A shorter pulse or a run of bounces produces no press and leaves `lamp_on` unchanged.
- R5: Only a rising edge of the accepted remote level is a press. Releasing the remote does not change `lamp_on`.
- R6: Each press, shown as `remote_event` high for one cycle, sets `lamp_on` to the complement of its present value in the next cycle. This works any number of times within one day or night period.
- R7: If a dusk or dawn pulse and a press occur in the same cycle, the dusk or dawn pulse decides the next `lamp_on` and the press is dropped.
- R8: In a cycle with no dusk pulse, no dawn pulse and no press, `lamp_on` keeps its value.
- R9: Latency is measured in clock edges. A change of `day_night` set up before edge k shows its pulse in the cycle after edge k+1. A steady `remote_raw` rise set up before edge k shows `remote_event` in the cycle after edge k+1+`DEBOUNCE_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| day_night | input | 1 | Sensed light level, 1 = night, 0 = day |
| remote_raw | input | 1 | Unfiltered remote receiver level, high while pressed |
| lamp_on | output | 1 | Lamp enable |
| dusk_pulse | output | 1 | One-cycle pulse on a day-to-night change |
| dawn_pulse | output | 1 | One-cycle pulse on a night-to-day change |
| remote_event | output | 1 | One-cycle pulse on an accepted remote press |

## Verification
The bench builds the block with `DEBOUNCE_CYCLES` set to 4 rather than the default of 16. This keeps the acceptance window short, so the exact press latency of six edges can be checked at single-cycle resolution. It also makes the boundary reachable within a few cycles: a pulse of three cycles must be rejected and a pulse of four accepted. With the short window, a press can also be aligned to land in the same cycle as a dusk pulse, which tests the priority rule. It also leaves room for several presses within one night to be walked through the vector table.

// File: rtl/lampctl_pkg.sv
// Shared types for the dusk/dawn lamp controller.
// Assumes: nothing beyond a single clock domain for all users.
package lampctl_pkg;

    // Next-state action selected for the lamp register.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_ON   = 2'd1,
        ACT_OFF  = 2'd2,
        ACT_FLIP = 2'd3
    } lamp_act_e;

endpackage

// File: rtl/lc_sync.sv
// Two-flop synchronizer, one chain per bit.
// Assumes: each bit is an independent slow level; no reset is needed,
// since the chain settles within two cycles of any steady input.
module lc_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic meta_q;
            logic safe_q;

            // Shift the asynchronous level through two flops.
            always_ff @(posedge clk) begin
                meta_q <= d[b];
                safe_q <= meta_q;
            end

            assign q[b] = safe_q;
        end
    endgenerate

endmodule

// File: rtl/lc_edge.sv
// Rising and falling edge detector on synchronized levels.
// Assumes: the inputs are already in the clk domain. Reset loads the
// history with the present level, so no edge is reported for a level
// that was already present during reset.
module lc_edge #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] hist_q;

    // Remember the last level; reset loads the present one.
    always_ff @(posedge clk) begin
        hist_q <= lvl;
    end

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_det
            assign rise[b] = rst_n &  lvl[b] & ~hist_q[b];
            assign fall[b] = rst_n & ~lvl[b] &  hist_q[b];
        end
    endgenerate

endmodule

// File: rtl/lc_debounce.sv
// Counter debouncer with rising-edge press output.
// Assumes: raw is synchronized. A new level is taken only after it has
// differed from the accepted one on CYCLES consecutive edges. press is
// high for one cycle after the accepted level rises.
module lc_debounce #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic press
);

    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] run_q;
    logic          level_q;
    logic          level_d1_q;

    // Count consecutive disagreeing samples; adopt the level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            level_q <= raw;
        end else if (raw != level_q) begin
            if (run_q == LAST) begin
                run_q   <= '0;
                level_q <= raw;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    // Keep the previous accepted level for edge detection.
    always_ff @(posedge clk) begin
        level_d1_q <= level_q;
    end

    assign press = rst_n & level_q & ~level_d1_q;

endmodule

// File: rtl/dusk_dawn_lamp.sv
// Lamp controller: forced on at dusk, forced off at dawn, and flipped
// by each debounced remote press.
// Assumes: day_night is a clean level (1 = night) and remote_raw is
// noisy; both are asynchronous to clk. Dusk/dawn outrank a press.
module dusk_dawn_lamp #(
    parameter int DEBOUNCE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic day_night,
    input  logic remote_raw,
    output logic lamp_on,
    output logic dusk_pulse,
    output logic dawn_pulse,
    output logic remote_event
);
    import lampctl_pkg::*;

    localparam int NSYNC = 2;
    localparam int IDX_DN  = 0;
    localparam int IDX_REM = 1;

    logic [NSYNC-1:0] sync_lvl;
    logic [0:0]       dn_rise;
    logic [0:0]       dn_fall;
    logic             press;
    lamp_act_e        act;
    logic             lamp_q;

    lc_sync #(.WIDTH(NSYNC)) u_sync (
        .clk (clk),
        .d   ({remote_raw, day_night}),
        .q   (sync_lvl)
    );

    lc_edge #(.WIDTH(1)) u_dn_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sync_lvl[IDX_DN +: 1]),
        .rise  (dn_rise),
        .fall  (dn_fall)
    );

    lc_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (sync_lvl[IDX_REM]),
        .press (press)
    );

    // Pick the lamp action; dusk/dawn win over a press.
    always_comb begin
        if (dn_rise[0])      act = ACT_ON;
        else if (dn_fall[0]) act = ACT_OFF;
        else if (press)      act = ACT_FLIP;
        else                 act = ACT_HOLD;
    end

    // Lamp state register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lamp_q <= 1'b0;
        end else begin
            case (act)
                ACT_ON:   lamp_q <= 1'b1;
                ACT_OFF:  lamp_q <= 1'b0;
                ACT_FLIP: lamp_q <= ~lamp_q;
                default:  lamp_q <= lamp_q;
            endcase
        end
    end

    assign lamp_on      = lamp_q;
    assign dusk_pulse   = dn_rise[0];
    assign dawn_pulse   = dn_fall[0];
    assign remote_event = press;

endmodule

// File: rtl/dusk_dawn_lamp_chk.sv
// Property checker for the lamp controller, bound to its ports.
// Assumes: observes ports only; all properties are idle during reset.
module dusk_dawn_lamp_chk (
    input logic clk,
    input logic rst_n,
    input logic lamp_on,
    input logic dusk_pulse,
    input logic dawn_pulse,
    input logic remote_event
);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !lamp_on);

    a_r2_dusk_single: assert property (@(posedge clk) disable iff (!rst_n)
        dusk_pulse |=> !dusk_pulse);

    a_r2_dusk_sets: assert property (@(posedge clk) disable iff (!rst_n)
        dusk_pulse |=> lamp_on);

    a_r3_dawn_single: assert property (@(posedge clk) disable iff (!rst_n)
        dawn_pulse |=> !dawn_pulse);

    a_r3_dawn_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dawn_pulse |=> !lamp_on);

    a_r3_lines_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(dusk_pulse && dawn_pulse));

    a_r4_press_single: assert property (@(posedge clk) disable iff (!rst_n)
        remote_event |=> !remote_event);

    a_r6_press_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (remote_event && !dusk_pulse && !dawn_pulse) |=> (lamp_on != $past(lamp_on)));

    a_r7_dusk_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (remote_event && dusk_pulse) |=> lamp_on);

    a_r8_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!remote_event && !dusk_pulse && !dawn_pulse) |=> $stable(lamp_on));

endmodule

bind dusk_dawn_lamp dusk_dawn_lamp_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lamp_on      (lamp_on),
    .dusk_pulse   (dusk_pulse),
    .dawn_pulse   (dawn_pulse),
    .remote_event (remote_event)
);

// File: tb/tb_dusk_dawn_lamp.sv
`timescale 1ns/1ps
module tb_dusk_dawn_lamp;

    localparam int DEB = 4;
    localparam int NV  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic day_night = 1'b0;
    logic remote_raw = 1'b0;
    logic lamp_on, dusk_pulse, dawn_pulse, remote_event;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dusk_dawn_lamp #(.DEBOUNCE_CYCLES(DEB)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .day_night    (day_night),
        .remote_raw   (remote_raw),
        .lamp_on      (lamp_on),
        .dusk_pulse   (dusk_pulse),
        .dawn_pulse   (dawn_pulse),
        .remote_event (remote_event)
    );

    // Vector: {day_night, remote_raw, wait[7:0], expected lamp, req[3:0]}
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'd4,  1'b1, 4'd2},  // R2 dusk turns lamp on
        {1'b1, 1'b1, 8'd10, 1'b0, 4'd6},  // R6 press flips off
        {1'b1, 1'b0, 8'd10, 1'b0, 4'd5},  // R5 release no effect
        {1'b1, 1'b1, 8'd10, 1'b1, 4'd6},  // R6 second press same night
        {1'b1, 1'b0, 8'd10, 1'b1, 4'd5},  // R5
        {1'b1, 1'b1, 8'd10, 1'b0, 4'd6},  // R6 third press same night
        {1'b1, 1'b0, 8'd10, 1'b0, 4'd8},  // R8 hold
        {1'b0, 1'b0, 8'd4,  1'b0, 4'd3},  // R3 dawn with lamp already off
        {1'b0, 1'b1, 8'd10, 1'b1, 4'd6},  // R6 press during day
        {1'b0, 1'b0, 8'd10, 1'b1, 4'd5},  // R5
        {1'b1, 1'b0, 8'd4,  1'b1, 4'd2},  // R2 dusk with lamp already on
        {1'b0, 1'b0, 8'd4,  1'b0, 4'd3}   // R3 dawn clears
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        bit seen;
        // R1 reset state
        tick(6);
        chk("R1", lamp_on, 1'b0, "lamp in reset");
        chk("R1", dusk_pulse | dawn_pulse | remote_event, 1'b0, "pulses in reset");
        rst_n = 1'b1;
        tick(4);
        chk("R1", lamp_on, 1'b0, "lamp after release");

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            day_night  = VEC[i][14];
            remote_raw = VEC[i][13];
            tick(int'(VEC[i][12:5]));
            chk($sformatf("R%0d", VEC[i][3:0]), lamp_on, VEC[i][4],
                $sformatf("vector %0d", i));
        end

        // R9 / R2 dusk latency: pulse after second edge, lamp one later
        day_night = 1'b1;
        tick(1); chk("R9", dusk_pulse, 1'b0, "dusk early");
        tick(1); chk("R9", dusk_pulse, 1'b1, "dusk on time");
        chk("R2", lamp_on, 1'b0, "lamp before dusk takes effect");
        tick(1); chk("R2", dusk_pulse, 1'b0, "dusk one cycle");
        chk("R2", lamp_on, 1'b1, "lamp after dusk");

        // R3 dawn latency and separate line
        day_night = 1'b0;
        tick(2); chk("R3", dawn_pulse, 1'b1, "dawn on time");
        chk("R3", dusk_pulse, 1'b0, "dusk quiet at dawn");
        tick(1); chk("R3", dawn_pulse, 1'b0, "dawn one cycle");
        chk("R3", lamp_on, 1'b0, "lamp after dawn");

        // R9 press latency: DEB+2 edges
        remote_raw = 1'b1;
        tick(DEB + 1); chk("R9", remote_event, 1'b0, "press early");
        tick(1);       chk("R9", remote_event, 1'b1, "press on time");
        tick(1);       chk("R6", remote_event, 1'b0, "press one cycle");
        chk("R6", lamp_on, 1'b1, "lamp flipped by press");
        remote_raw = 1'b0;
        tick(12);
        chk("R5", lamp_on, 1'b1, "release keeps lamp");

        // R4 short pulse of DEB-1 cycles is rejected
        seen = 1'b0;
        remote_raw = 1'b1;
        for (int c = 0; c < DEB - 1; c++) begin tick(1); seen |= remote_event; end
        remote_raw = 1'b0;
        for (int c = 0; c < 12; c++) begin tick(1); seen |= remote_event; end
        chk("R4", seen, 1'b0, "short pulse press");
        chk("R4", lamp_on, 1'b1, "short pulse lamp");

        // R4 bounce then steady high: exactly one flip
        for (int c = 0; c < 6; c++) begin
            remote_raw = ~remote_raw;
            tick(2);
        end
        remote_raw = 1'b1;
        tick(14);
        chk("R4", lamp_on, 1'b0, "bounce gives one flip");
        remote_raw = 1'b0;
        tick(12);

        // R8 idle hold
        seen = 1'b0;
        for (int c = 0; c < 20; c++) begin tick(1); seen |= (lamp_on !== 1'b0); end
        chk("R8", seen, 1'b0, "lamp changed while idle");

        // R7 priority: lamp on in day, press and dusk in the same cycle
        remote_raw = 1'b1; tick(10); remote_raw = 1'b0; tick(12);
        chk("R6", lamp_on, 1'b1, "setup press in day");
        remote_raw = 1'b1;
        tick(DEB);
        day_night = 1'b1;
        tick(2);
        chk("R7", dusk_pulse & remote_event, 1'b1, "coincident pulses");
        tick(1);
        chk("R7", lamp_on, 1'b1, "dusk wins over press");
        remote_raw = 1'b0;
        tick(12);
        chk("R7", lamp_on, 1'b1, "lamp after priority case");

        // R1 reset with both inputs high: no false edge on release
        rst_n = 1'b0;
        remote_raw = 1'b1;
        tick(6);
        chk("R1", lamp_on, 1'b0, "lamp cleared by reset");
        rst_n = 1'b1;
        seen = 1'b0;
        for (int c = 0; c < 12; c++) begin
            tick(1);
            seen |= dusk_pulse | dawn_pulse | remote_event | lamp_on;
        end
        chk("R1", seen, 1'b0, "activity after release");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule